// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit processor. It fetches one instruction byte at a time into an opcode register and uses the upper nibble of that byte to look up where the instruction's routine starts in a microinstruction store. It then steps through the routine, one microinstruction per clock. Each microinstruction drives the instruction pointer, resolves the operand register selects and passes a field of datapath controls outward.

Any microinstruction can be made to depend on the ALU flags through a 4-bit condition code. A failed condition cancels every action that the step would have taken. A routine can end by loading the next opcode, bumping the pointer and dispatching to the new entry point in that same step, so it never passes through the shared fetch routine. The microprogram and the entry table are built into the module. The datapath and both memories sit outside it.

The microinstruction word is 32 bits. Bits [1:0] hold the next-address mode and bits [5:2] the condition code. Bit 6 loads the opcode, bit 7 increments the pointer, bit 8 loads the pointer and bit 9 decrements it. Bits [11:10] hold the source-select mode, bits [13:12] the destination-select mode, bits [15:14] a register index supplied by the microword, and bits [31:16] the datapath control field.

Top module: `ucode_sequencer`

## Requirements
- R1: With `rst` high at a rising edge, the block afterwards shows `upc` = 0, `ip` = 0x0000 and `opcode` = 0x00, and it runs microword 0 first.
- R2: Next-address mode 0 makes the following `upc` equal to the current `upc` + 1, wrapping modulo 256.
- R3: Next-address mode 1 takes the next `upc` from the entry table, which is indexed by the upper opcode nibble. Nibble 0 goes to 1, 1 to 2, 2 to 3, 3 to 4, 4 to 7 and 5 to 10. Every other nibble goes to 0.
- R4: A step that loads the opcode, increments the pointer and uses mode 1 does all of the following on one edge: it stores `instr_byte` in `opcode`, advances `ip` by one and sets `upc` to the entry of `instr_byte[7:4]`.
- R5: Next-address modes 2 and 3 both make the following `upc` equal to 0.
- R6: Among the pointer actions that pass their condition, a load (`ip` takes `ip_load_val`) has priority over an increment, and an increment has priority over a decrement. The pointer wraps modulo 2^16. With no action, `ip` holds its value.
- R7: Condition codes work as follows. Code 0 is always true. Codes 1 to 8 test, in order, Z, not Z, C, not C, S, not S, V and not V, where `flags` bit 0 is Z, bit 1 is C, bit 2 is S and bit 3 is V. Codes 9 to 14 are never true. Code 15 applies the opcode's low nibble as the code, and in that case 9 to 15 mean never.
- R8: When a step's condition fails, the step does not load the opcode and does not load, increment or decrement `ip`. `dp_ctrl` reads 0 and both selects read 0xFF. The next-address mode still applies, and mode 1 then indexes with the current opcode.
- R9: Select modes resolve as follows. Mode 0 gives opcode bits [3:2], mode 1 gives opcode bits [1:0], and mode 2 gives the microword register field, each zero-extended. Mode 3 gives 0xFF.
- R10: While the condition holds, `dp_ctrl` equals microword bits [31:16]. Bit 0 is register write, bit 1 is flag write, bits [4:2] are the ALU operation (1 = add), bit 5 loads the low immediate and bit 6 loads the high immediate.
- R11: The built-in routines are as follows. Word 0 is an idle step going to 1. Word 1 is the fetch step (opcode load, increment, mode 1). A move (word 2) writes select 1 into select 0 using the fast path. An add (word 3) is the same plus flag write and ALU op 1. A jump runs words 4, 5 and 6: load the low immediate and increment, load the high immediate and increment, then load `ip` under code 15 and go to 0. A constant runs words 7, 8 and 9: load the low immediate and increment, then write microword register 3 into select 1, then the fast path. Word 10 decrements `ip` and uses mode 3. Every other word uses mode 2 and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_byte | input | OPC_W | Instruction memory byte at address `ip` |
| flags | input | 4 | ALU flags {V,S,C,Z} |
| ip_load_val | input | IP_W | Jump target assembled by the datapath from the immediates |
| ip | output | IP_W | Instruction pointer |
| opcode | output | OPC_W | Opcode register |
| upc | output | UADDR_W | Microprogram counter |
| src_sel | output | SEL_W | Resolved source register select, all ones for none |
| dst_sel | output | SEL_W | Resolved destination register select, all ones for none |
| dp_ctrl | output | 16 | Datapath control field, gated by the condition |

## Verification
The bench builds the block with its default parameters: a 256-word store, a 16-bit pointer and 8-bit opcodes. Its instruction memory is 64 bytes, addressed by the low six bits of `ip`. Random instruction bytes reach every opcode nibble, including the unmapped ones, and every condition code that a jump carries. Jump targets of 0xFFFF are driven on purpose, so that the next fetch increment shows the pointer wrapping to zero.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  localparam int CC_W  = 4;
  localparam int DP_W  = 16;
  localparam int UF_W  = 2;

  localparam logic [1:0] NX_NEXT    = 2'd0;
  localparam logic [1:0] NX_START   = 2'd1;
  localparam logic [1:0] NX_FETCH   = 2'd2;
  localparam logic [1:0] NX_RESTART = 2'd3;

  localparam logic [1:0] SEL_P1   = 2'd0;
  localparam logic [1:0] SEL_P2   = 2'd1;
  localparam logic [1:0] SEL_UF   = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  localparam logic [CC_W-1:0] CC_ALW   = 4'd0;
  localparam logic [CC_W-1:0] CC_PARAM = 4'd15;

  localparam logic [DP_W-1:0] DP_REG_WR   = 16'h0001;
  localparam logic [DP_W-1:0] DP_FLAGS_WR = 16'h0002;
  localparam logic [DP_W-1:0] DP_ALU_ADD  = 16'h0004;
  localparam logic [DP_W-1:0] DP_IMML     = 16'h0020;
  localparam logic [DP_W-1:0] DP_IMMH     = 16'h0040;

  typedef struct packed {
    logic [DP_W-1:0] dp;
    logic [UF_W-1:0] ufield;
    logic [1:0]      dst_mode;
    logic [1:0]      src_mode;
    logic            ip_dec;
    logic            ip_ld;
    logic            ip_inc;
    logic            opc_ld;
    logic [CC_W-1:0] cond;
    logic [1:0]      nxt;
  } uword_t;

  function automatic uword_t mk(input logic [1:0] nxt, input logic [CC_W-1:0] cc,
                                input logic opl, input logic inc, input logic ld,
                                input logic dec, input logic [1:0] sm,
                                input logic [1:0] dm, input logic [UF_W-1:0] uf,
                                input logic [DP_W-1:0] dp);
    uword_t w;
    w.nxt = nxt;  w.cond = cc;   w.opc_ld = opl; w.ip_inc = inc;
    w.ip_ld = ld; w.ip_dec = dec; w.src_mode = sm; w.dst_mode = dm;
    w.ufield = uf; w.dp = dp;
    return w;
  endfunction

  function automatic uword_t uword_at(input int a);
    case (a)
      0:  return mk(NX_NEXT,  CC_ALW, 1'b0, 1'b0, 1'b0, 1'b0, SEL_NONE, SEL_NONE, 2'd0, '0);
      1:  return mk(NX_START, CC_ALW, 1'b1, 1'b1, 1'b0, 1'b0, SEL_NONE, SEL_NONE, 2'd0, '0);
      2:  return mk(NX_START, CC_ALW, 1'b1, 1'b1, 1'b0, 1'b0, SEL_P2, SEL_P1, 2'd0, DP_REG_WR);
      3:  return mk(NX_START, CC_ALW, 1'b1, 1'b1, 1'b0, 1'b0, SEL_P2, SEL_P1, 2'd0,
                    DP_REG_WR | DP_FLAGS_WR | DP_ALU_ADD);
      4:  return mk(NX_NEXT,  CC_ALW, 1'b0, 1'b1, 1'b0, 1'b0, SEL_NONE, SEL_NONE, 2'd0, DP_IMML);
      5:  return mk(NX_NEXT,  CC_ALW, 1'b0, 1'b1, 1'b0, 1'b0, SEL_NONE, SEL_NONE, 2'd0, DP_IMMH);
      6:  return mk(NX_FETCH, CC_PARAM, 1'b0, 1'b0, 1'b1, 1'b0, SEL_NONE, SEL_NONE, 2'd0, '0);
      7:  return mk(NX_NEXT,  CC_ALW, 1'b0, 1'b1, 1'b0, 1'b0, SEL_NONE, SEL_NONE, 2'd0, DP_IMML);
      8:  return mk(NX_NEXT,  CC_ALW, 1'b0, 1'b0, 1'b0, 1'b0, SEL_UF, SEL_P2, 2'd3, DP_REG_WR);
      9:  return mk(NX_START, CC_ALW, 1'b1, 1'b1, 1'b0, 1'b0, SEL_NONE, SEL_NONE, 2'd0, '0);
      10: return mk(NX_RESTART, CC_ALW, 1'b0, 1'b0, 1'b0, 1'b1, SEL_NONE, SEL_NONE, 2'd0, '0);
      default: return mk(NX_FETCH, CC_ALW, 1'b0, 1'b0, 1'b0, 1'b0, SEL_NONE, SEL_NONE, 2'd0, '0);
    endcase
  endfunction

  function automatic int entry_at(input int op);
    case (op)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 7;
      5: return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(ucseq_pkg::uword_at(i));
  end

  // synchronous read port, the caller presents the next address
  always_ff @(posedge clk) rd_data <= mem[rd_addr];
endmodule

// File: rtl/ucseq_entry.sv
module ucseq_entry #(
  parameter int IW = 4,
  parameter int AW = 8
) (
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] entry
);
  localparam int N = 1 << IW;

  logic [AW-1:0] tbl [N];

  initial begin
    for (int i = 0; i < N; i++) tbl[i] = AW'(ucseq_pkg::entry_at(i));
  end

  assign entry = tbl[idx];
endmodule

// File: rtl/ucseq_cond.sv
module ucseq_cond #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] code,
  input  logic [CW-1:0] param,
  input  logic [3:0]    flags,
  output logic          ok
);
  localparam logic [CW-1:0] USE_PARAM = '1;

  function automatic logic eval(input logic [CW-1:0] c, input logic [3:0] f);
    case (c)
      CW'(0): return 1'b1;
      CW'(1): return f[0];
      CW'(2): return ~f[0];
      CW'(3): return f[1];
      CW'(4): return ~f[1];
      CW'(5): return f[2];
      CW'(6): return ~f[2];
      CW'(7): return f[3];
      CW'(8): return ~f[3];
      default: return 1'b0;
    endcase
  endfunction

  always_comb ok = (code == USE_PARAM) ? eval(param, flags) : eval(code, flags);
endmodule

// File: rtl/ucseq_ptr.sv
module ucseq_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic         dec,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (ld)  ptr <= ld_val;
    else if (inc) ptr <= ptr + 1'b1;
    else if (dec) ptr <= ptr - 1'b1;
  end

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    ld |=> ptr == $past(ld_val));
  p_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld) |=> ptr == W'($past(ptr) + 1'b1));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld && !dec) |=> $stable(ptr));
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int UADDR_W = 8,
  parameter int IP_W    = 16,
  parameter int OPC_W   = 8,
  parameter int SEL_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   instr_byte,
  input  logic [3:0]         flags,
  input  logic [IP_W-1:0]    ip_load_val,
  output logic [IP_W-1:0]    ip,
  output logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] upc,
  output logic [SEL_W-1:0]   src_sel,
  output logic [SEL_W-1:0]   dst_sel,
  output logic [15:0]        dp_ctrl
);
  import ucseq_pkg::*;

  localparam int UW_W  = $bits(uword_t);
  localparam int NIB_W = OPC_W / 2;

  logic [UW_W-1:0]    rom_q;
  uword_t             uw;
  logic [UADDR_W-1:0] upc_q, upc_nxt, rd_addr, entry;
  logic [OPC_W-1:0]   opc_q;
  logic [NIB_W-1:0]   start_idx;
  logic               cond_ok, opc_ld_e, inc_e, ld_e, dec_e;

  assign uw = uword_t'(rom_q);

  ucseq_store #(.AW(UADDR_W), .DW(UW_W)) u_store (
    .clk(clk), .rd_addr(rd_addr), .rd_data(rom_q));

  ucseq_cond #(.CW(CC_W)) u_cond (
    .code(uw.cond), .param(opc_q[CC_W-1:0]), .flags(flags), .ok(cond_ok));

  assign opc_ld_e = uw.opc_ld & cond_ok;
  assign inc_e    = uw.ip_inc & cond_ok;
  assign ld_e     = uw.ip_ld  & cond_ok;
  assign dec_e    = uw.ip_dec & cond_ok;

  // fast path: the freshly fetched byte picks the entry in the same step
  assign start_idx = opc_ld_e ? instr_byte[OPC_W-1 -: NIB_W] : opc_q[OPC_W-1 -: NIB_W];

  ucseq_entry #(.IW(NIB_W), .AW(UADDR_W)) u_entry (.idx(start_idx), .entry(entry));

  ucseq_ptr #(.W(IP_W)) u_ptr (
    .clk(clk), .rst(rst), .inc(inc_e), .ld(ld_e), .dec(dec_e),
    .ld_val(ip_load_val), .ptr(ip));

  always_comb begin
    case (uw.nxt)
      NX_NEXT:  upc_nxt = upc_q + 1'b1;
      NX_START: upc_nxt = entry;
      default:  upc_nxt = '0;
    endcase
  end

  assign rd_addr = rst ? '0 : upc_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q <= '0;
      opc_q <= '0;
    end else begin
      upc_q <= upc_nxt;
      if (opc_ld_e) opc_q <= instr_byte;
    end
  end

  function automatic logic [SEL_W-1:0] resolve(input logic [1:0] mode,
                                               input logic [OPC_W-1:0] op,
                                               input logic [UF_W-1:0] uf);
    case (mode)
      SEL_P1:  return SEL_W'(op[3:2]);
      SEL_P2:  return SEL_W'(op[1:0]);
      SEL_UF:  return SEL_W'(uf);
      default: return '1;
    endcase
  endfunction

  assign src_sel = cond_ok ? resolve(uw.src_mode, opc_q, uw.ufield) : '1;
  assign dst_sel = cond_ok ? resolve(uw.dst_mode, opc_q, uw.ufield) : '1;
  assign dp_ctrl = cond_ok ? uw.dp : '0;

  assign upc    = upc_q;
  assign opcode = opc_q;

  p_next_step_r2: assert property (@(posedge clk) disable iff (rst)
    (uw.nxt == NX_NEXT) |=> upc_q == UADDR_W'($past(upc_q) + 1'b1));
  p_fetch_return_r5: assert property (@(posedge clk) disable iff (rst)
    uw.nxt[1] |=> upc_q == '0);
  p_fast_path_r4: assert property (@(posedge clk) disable iff (rst)
    (opc_ld_e && uw.nxt == NX_START) |=> opc_q == $past(instr_byte));
  p_cond_keeps_opc_r8: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |=> opc_q == $past(opc_q));
endmodule

// File: tb/ucode_sequencer_test.sv
`timescale 1ns/1ps
module ucode_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  flags = '0;
  logic [15:0] ldval = '0;
  logic [7:0]  instr_byte;
  logic [15:0] ip;
  logic [7:0]  opcode, upc, src_sel, dst_sel;
  logic [15:0] dp_ctrl;
  logic [7:0]  imem [64];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign instr_byte = imem[ip[5:0]];

  ucode_sequencer uut (
    .clk(clk), .rst(rst), .instr_byte(instr_byte), .flags(flags),
    .ip_load_val(ldval), .ip(ip), .opcode(opcode), .upc(upc),
    .src_sel(src_sel), .dst_sel(dst_sel), .dp_ctrl(dp_ctrl));

  typedef struct packed {
    logic [1:0] nx; logic [3:0] cc; logic opl, inc, ld, dec;
    logic [1:0] sm, dm, uf; logic [15:0] dp;
  } mstep_t;

  // microprogram as listed in R11
  function automatic mstep_t step_at(input int a);
    mstep_t s = '0;
    s.sm = 2'd3; s.dm = 2'd3; s.nx = 2'd2;
    case (a)
      0:  s.nx = 2'd0;
      1:  begin s.nx = 2'd1; s.opl = 1; s.inc = 1; end
      2:  begin s.nx = 2'd1; s.opl = 1; s.inc = 1; s.sm = 1; s.dm = 0; s.dp = 16'h0001; end
      3:  begin s.nx = 2'd1; s.opl = 1; s.inc = 1; s.sm = 1; s.dm = 0; s.dp = 16'h0007; end
      4:  begin s.nx = 2'd0; s.inc = 1; s.dp = 16'h0020; end
      5:  begin s.nx = 2'd0; s.inc = 1; s.dp = 16'h0040; end
      6:  begin s.nx = 2'd2; s.cc = 4'd15; s.ld = 1; end
      7:  begin s.nx = 2'd0; s.inc = 1; s.dp = 16'h0020; end
      8:  begin s.nx = 2'd0; s.sm = 2; s.dm = 1; s.uf = 2'd3; s.dp = 16'h0001; end
      9:  begin s.nx = 2'd1; s.opl = 1; s.inc = 1; end
      10: begin s.nx = 2'd3; s.dec = 1; end
      default: ;
    endcase
    return s;
  endfunction

  function automatic logic [7:0] entry_of(input logic [3:0] n);
    case (n)
      4'd0: return 8'd1;  4'd1: return 8'd2;  4'd2: return 8'd3;
      4'd3: return 8'd4;  4'd4: return 8'd7;  4'd5: return 8'd10;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic cc_eval(input logic [3:0] c, input logic [3:0] f);
    case (c)
      4'd0: return 1'b1; 4'd1: return f[0]; 4'd2: return !f[0];
      4'd3: return f[1]; 4'd4: return !f[1]; 4'd5: return f[2];
      4'd6: return !f[2]; 4'd7: return f[3]; 4'd8: return !f[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] sel_of(input logic [1:0] m, input logic [7:0] op,
                                        input logic [1:0] uf);
    case (m)
      2'd0: return {6'b0, op[3:2]};
      2'd1: return {6'b0, op[1:0]};
      2'd2: return {6'b0, uf};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [7:0]  e_upc, e_opc;
  logic [15:0] e_ip;
  string       upc_tag, ip_tag;

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_upc = 0; e_opc = 0; e_ip = 0;
    upc_tag = "R1"; ip_tag = "R1";
    #1;
    check("R1", "upc after reset", upc, 0);
    check("R1", "ip after reset", ip, 0);
    check("R1", "opcode after reset", opcode, 0);
  endtask

  // one cycle: check current state and outputs, then advance the model
  task automatic cycle(input logic [3:0] f, input logic [15:0] lv);
    mstep_t s;
    logic ok;
    logic [7:0] ib;
    flags = f; ldval = lv;
    #1;
    check(upc_tag, "upc", upc, e_upc);
    check(ip_tag, "ip", ip, e_ip);
    check("R4", "opcode", opcode, e_opc);
    s  = step_at(int'(e_upc));
    ok = (s.cc == 4'd15) ? cc_eval(e_opc[3:0], f) : cc_eval(s.cc, f);
    ib = imem[e_ip[5:0]];
    check(ok ? (s.cc != 0 ? "R7" : "R10") : "R8", "dp_ctrl", dp_ctrl, ok ? s.dp : 16'h0);
    check(ok ? "R9" : "R8", "src_sel", src_sel, ok ? sel_of(s.sm, e_opc, s.uf) : 8'hFF);
    check(ok ? "R9" : "R8", "dst_sel", dst_sel, ok ? sel_of(s.dm, e_opc, s.uf) : 8'hFF);
    ip_tag = (e_upc == 8'd6) ? "R11" : "R6";
    case (s.nx)
      2'd0: begin upc_tag = "R2"; e_upc = e_upc + 8'd1; end
      2'd1: begin
        upc_tag = (s.opl && ok) ? "R4" : "R3";
        e_upc = entry_of((s.opl && ok) ? ib[7:4] : e_opc[7:4]);
      end
      default: begin upc_tag = "R5"; e_upc = 8'd0; end
    endcase
    if (s.opl && ok) e_opc = ib;
    if (ok && s.ld)       e_ip = lv;
    else if (ok && s.inc) e_ip = e_ip + 16'd1;
    else if (ok && s.dec) e_ip = e_ip - 16'd1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) imem[i] = 8'h00;
    // directed: mov, add, taken jump, not-taken jump, const, back-step loop
    imem[0] = 8'h1B; imem[1] = 8'h26;
    imem[2] = 8'h30; imem[3] = 8'h10; imem[4] = 8'h00;
    imem[16] = 8'h31; imem[17] = 8'h22; imem[18] = 8'h00;
    imem[19] = 8'h42; imem[20] = 8'h5A;
    imem[21] = 8'h50;
    do_reset();
    for (int c = 0; c < 40; c++) cycle(4'h0, 16'h0010);
    // directed: taken jump to 0xFFFF, next fetch wraps ip to 0
    for (int i = 0; i < 64; i++) imem[i] = 8'h00;
    imem[0] = 8'h32; imem[63] = 8'h1B;
    do_reset();
    for (int c = 0; c < 12; c++) cycle(4'h0, 16'hFFFF);
    // random programs, flags and targets
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 64; i++) imem[i] = 8'($urandom);
      do_reset();
      for (int c = 0; c < 2000; c++)
        cycle(4'($urandom), ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule